// File: doc/BRIEF.md
# System Clock Divider and Gating

This block turns a free-running system clock into two periodic single-cycle enables. The first is a switching-rate tick, chosen from a 3-bit ratio code. The second is a serial bit-clock tick, chosen from a 4-bit ratio code. The switching path also drives a fixed divide-by-two stage, which produces a square switching clock at half the tick rate. Logic downstream runs on the system clock and advances only on the ticks, so the block contains no derived clock nets.

The block also turns two enable inputs into registered, glitch-free gate enables. One is for the whole digital core. The other is for the DSP domain alone, and it can only be high while the core enable is high. When the system enable is low, both counters freeze and no tick is produced. A ratio code may change at any time, but the new ratio is loaded only when the current count period ends. A shortened period therefore never appears on a tick output.

Top module: `sysclk_div_gate`

## Requirements
- R1: The switching code selects a ratio N of 1, 2, 3, 4, 6, 8, 12 or 16 for codes 0 through 7 in that order. `sw_tick` is high for one cycle out of every N enabled cycles.
- R2: After reset the active switching ratio is 16. The first `sw_tick` is seen in the cycle after the 16th enabled clock edge.
- R3: `sw_clk` is 0 in reset. It inverts on the clock edge that follows each `sw_tick` cycle and holds otherwise, so its period is 2N.
- R4: The bit-clock code selects ratio 1 for 0000, 2 for 0010, 3 for 0011, 4 for 0100, 6 for 0110 and 8 for 0111. `bck_tick` is high for one cycle out of every N enabled cycles.
- R5: Bit-clock codes 0001 and 0101, and every code from 1000 up, all give a ratio of 4.
- R6: After reset the active bit-clock ratio is 4.
- R7: A code change takes effect only at the end of the current period. The period in progress keeps the old length, and every period after it has the new length.
- R8: A ratio of 1 holds its tick high on every enabled cycle.
- R9: While `sys_en` is low, both counters hold and both ticks stay low, and `sw_clk` holds. When `sys_en` returns, counting continues from the held count.
- R10: `core_en` is 1 in reset and, after reset, equals `sys_en` delayed by one cycle.
- R11: `dsp_gate_en` is 1 in reset and, after reset, equals `sys_en AND dsp_en` delayed by one cycle. It is never high while `core_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_div_code | input | 3 | Switching ratio code |
| bck_div_code | input | 4 | Bit-clock ratio code |
| sys_en | input | 1 | System enable; low freezes the dividers |
| dsp_en | input | 1 | DSP domain enable |
| sw_tick | output | 1 | Switching-rate one-cycle tick |
| sw_clk | output | 1 | Switching clock at half the tick rate |
| bck_tick | output | 1 | Bit-clock one-cycle tick |
| core_en | output | 1 | Registered digital core gate enable |
| dsp_gate_en | output | 1 | Registered DSP domain gate enable |

## Verification
Some properties are checked on every cycle: the ticks stay silent while the system enable is low, `sw_clk` changes exactly one cycle after each switching tick, and both gate enables follow their inputs with one cycle of latency, with the DSP enable contained in the core enable. Other behaviours only the directed scenarios can show, because they depend on counting across whole periods. These are the ratio decode of every code, the reserved-code fallback, the reset ratios, the deferred ratio change, and the period stretched by a pause in the enable.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    localparam int SW_CODE_W  = 3;
    localparam int BCK_CODE_W = 4;
    localparam int MAX_RATIO  = 16;
    localparam int CNT_W      = $clog2(MAX_RATIO);

    typedef logic [CNT_W-1:0] lim_t;

    // Switching ratio code -> terminal count (ratio minus one)
    function automatic lim_t sw_code_to_lim(input logic [SW_CODE_W-1:0] code);
        lim_t lim;
        case (code)
            3'd0:    lim = lim_t'(0);
            3'd1:    lim = lim_t'(1);
            3'd2:    lim = lim_t'(2);
            3'd3:    lim = lim_t'(3);
            3'd4:    lim = lim_t'(5);
            3'd5:    lim = lim_t'(7);
            3'd6:    lim = lim_t'(11);
            default: lim = lim_t'(15);
        endcase
        return lim;
    endfunction

    // Bit-clock ratio code -> terminal count; unlisted codes fall back to ratio 4
    function automatic lim_t bck_code_to_lim(input logic [BCK_CODE_W-1:0] code);
        lim_t lim;
        case (code)
            4'b0000: lim = lim_t'(0);
            4'b0010: lim = lim_t'(1);
            4'b0011: lim = lim_t'(2);
            4'b0110: lim = lim_t'(5);
            4'b0111: lim = lim_t'(7);
            default: lim = lim_t'(3);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/sdg_divider.sv
module sdg_divider #(
    parameter int              CNT_W   = 4,
    parameter logic [CNT_W-1:0] RST_LIM = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] lim_next,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (run) begin
            if (st_q.cnt == st_q.lim) begin
                st_d.cnt  = '0;
                st_d.lim  = lim_next;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.lim  <= RST_LIM;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/sdg_halver.sv
module sdg_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic half_clk
);

    typedef struct packed {
        logic lvl;
    } half_state_t;

    half_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = st_q.lvl ^ tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half_clk = st_q.lvl;

endmodule

// File: rtl/sdg_gate.sv
module sdg_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_en,
    input  logic dsp_en,
    output logic core_en,
    output logic dsp_gate_en
);

    typedef struct packed {
        logic core;
        logic dsp;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.core = sys_en;
        st_d.dsp  = sys_en & dsp_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.core <= 1'b1;
            st_q.dsp  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_en     = st_q.core;
    assign dsp_gate_en = st_q.dsp;

endmodule

// File: rtl/sysclk_div_gate.sv
module sysclk_div_gate
    import sdg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SW_CODE_W-1:0]  sw_div_code,
    input  logic [BCK_CODE_W-1:0] bck_div_code,
    input  logic                  sys_en,
    input  logic                  dsp_en,
    output logic                  sw_tick,
    output logic                  sw_clk,
    output logic                  bck_tick,
    output logic                  core_en,
    output logic                  dsp_gate_en
);

    localparam lim_t SW_RST_LIM  = sw_code_to_lim(3'b111);
    localparam lim_t BCK_RST_LIM = bck_code_to_lim(4'b0100);

    lim_t sw_lim_next;
    lim_t bck_lim_next;

    always_comb begin
        sw_lim_next  = sw_code_to_lim(sw_div_code);
        bck_lim_next = bck_code_to_lim(bck_div_code);
    end

    sdg_divider #(.CNT_W(CNT_W), .RST_LIM(SW_RST_LIM)) sw_div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sys_en),
        .lim_next (sw_lim_next),
        .tick     (sw_tick)
    );

    sdg_divider #(.CNT_W(CNT_W), .RST_LIM(BCK_RST_LIM)) bck_div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sys_en),
        .lim_next (bck_lim_next),
        .tick     (bck_tick)
    );

    sdg_halver half_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sw_tick),
        .half_clk (sw_clk)
    );

    sdg_gate gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_en      (sys_en),
        .dsp_en      (dsp_en),
        .core_en     (core_en),
        .dsp_gate_en (dsp_gate_en)
    );

endmodule

// File: rtl/sdg_checker.sv
module sdg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] sw_div_code,
    input logic [3:0] bck_div_code,
    input logic       sys_en,
    input logic       dsp_en,
    input logic       sw_tick,
    input logic       sw_clk,
    input logic       bck_tick,
    input logic       core_en,
    input logic       dsp_gate_en
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: a cycle with the system enable low yields no tick
    p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(sys_en)) |-> (!sw_tick && !bck_tick));

    // R3: the half-rate output changes exactly after a switching tick
    p_half_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((sw_clk != $past(sw_clk)) == $past(sw_tick)));

    // R10: core enable follows the system enable one cycle later
    p_core_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (core_en == $past(sys_en)));

    // R11: DSP enable follows the combined enables one cycle later
    p_dsp_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (dsp_gate_en == $past(sys_en && dsp_en)));

    // R11: DSP domain never enabled without the core
    p_dsp_inside_core_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_gate_en |-> core_en);

    // unused in properties, kept for bind symmetry
    logic unused_codes;
    assign unused_codes = ^{sw_div_code, bck_div_code};

endmodule

bind sysclk_div_gate sdg_checker chk_i (.*);

// File: tb/sysclk_div_gate_tb_top.sv
module sysclk_div_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sw_div_code = 3'b111;
    logic [3:0] bck_div_code = 4'b0100;
    logic       sys_en = 1'b1;
    logic       dsp_en = 1'b1;
    logic       sw_tick, sw_clk, bck_tick, core_en, dsp_gate_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sysclk_div_gate dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_div_code  (sw_div_code),
        .bck_div_code (bck_div_code),
        .sys_en       (sys_en),
        .dsp_en       (dsp_en),
        .sw_tick      (sw_tick),
        .sw_clk       (sw_clk),
        .bck_tick     (bck_tick),
        .core_en      (core_en),
        .dsp_gate_en  (dsp_gate_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sw_ratio(input int c);
        case (c)
            0: return 1;   1: return 2;   2: return 3;  3: return 4;
            4: return 6;   5: return 8;   6: return 12; default: return 16;
        endcase
    endfunction

    function automatic int bck_ratio(input int c);
        case (c)
            0: return 1;  2: return 2;  3: return 3;
            4: return 4;  6: return 6;  7: return 8;
            default: return 4;
        endcase
    endfunction

    // counts negedges until the selected tick is seen high
    task automatic wait_tick(input bit use_bck, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(use_bck ? bck_tick : sw_tick) && n < 200);
        if (n >= 200) chk("watchdog tick wait", n, 0);
    endtask

    task automatic do_reset();
        rst_n        = 1'b0;
        sw_div_code  = 3'b111;
        bck_div_code = 4'b0100;
        sys_en       = 1'b1;
        dsp_en       = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 sw_tick low in reset", int'(sw_tick), 0);
        chk("R6 bck_tick low in reset", int'(bck_tick), 0);
        chk("R3 sw_clk low in reset", int'(sw_clk), 0);
        chk("R10 core_en high in reset", int'(core_en), 1);
        chk("R11 dsp_gate_en high in reset", int'(dsp_gate_en), 1);
    endtask

    task automatic t_defaults();
        int n;
        do_reset();
        wait_tick(1'b0, n);
        chk("R2 first switching period", n, 16);
        do_reset();
        wait_tick(1'b1, n);
        chk("R6 first bit-clock period", n, 4);
        wait_tick(1'b1, n);
        chk("R6 second bit-clock period", n, 4);
    endtask

    task automatic t_sw_table();
        int n;
        do_reset();
        wait_tick(1'b0, n);
        for (int c = 0; c < 8; c++) begin
            sw_div_code = 3'(c);
            wait_tick(1'b0, n);
            wait_tick(1'b0, n);
            chk($sformatf("R1 switching code %0d", c), n, sw_ratio(c));
        end
    endtask

    task automatic t_bck_table();
        int n;
        do_reset();
        wait_tick(1'b1, n);
        for (int c = 0; c < 16; c++) begin
            bck_div_code = 4'(c);
            wait_tick(1'b1, n);
            wait_tick(1'b1, n);
            if (c == 1 || c == 5 || c > 7)
                chk($sformatf("R5 reserved bit-clock code %0d", c), n, 4);
            else
                chk($sformatf("R4 bit-clock code %0d", c), n, bck_ratio(c));
        end
    endtask

    task automatic t_ratio_one();
        int n;
        int highs;
        do_reset();
        wait_tick(1'b0, n);
        sw_div_code  = 3'd0;
        bck_div_code = 4'd0;
        wait_tick(1'b0, n);
        repeat (4) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            highs += int'(sw_tick) + int'(bck_tick);
        end
        chk("R8 both ticks high every cycle at ratio 1", highs, 16);
    endtask

    task automatic t_change_mid();
        int n;
        do_reset();
        wait_tick(1'b0, n);
        repeat (5) @(negedge clk);
        sw_div_code = 3'd1;
        wait_tick(1'b0, n);
        chk("R7 period in progress keeps old length", n + 5, 16);
        wait_tick(1'b0, n);
        chk("R7 next period uses new length", n, 2);
        wait_tick(1'b0, n);
        chk("R7 new length persists", n, 2);
    endtask

    task automatic t_hold();
        int n;
        int seen;
        bit clk_lvl;
        do_reset();
        wait_tick(1'b0, n);
        repeat (5) @(negedge clk);
        sys_en  = 1'b0;
        @(negedge clk);
        clk_lvl = sw_clk;
        seen = 0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            seen += int'(sw_tick) + int'(bck_tick) + int'(sw_clk != clk_lvl);
        end
        chk("R9 no tick and no sw_clk change while disabled", seen, 0);
        sys_en = 1'b1;
        wait_tick(1'b0, n);
        chk("R9 period stretched by paused cycles", n + 15, 26);
    endtask

    task automatic t_half_clk();
        int n;
        bit v0;
        do_reset();
        wait_tick(1'b0, n);
        sw_div_code = 3'd2;
        wait_tick(1'b0, n);
        wait_tick(1'b0, n);
        v0 = sw_clk;
        @(negedge clk);
        chk("R3 sw_clk inverts after tick", int'(sw_clk), int'(!v0));
        wait_tick(1'b0, n);
        chk("R3 sw_clk holds until next tick", int'(sw_clk), int'(!v0));
        @(negedge clk);
        chk("R3 sw_clk inverts again", int'(sw_clk), int'(v0));
    endtask

    task automatic t_gates();
        do_reset();
        @(negedge clk);
        dsp_en = 1'b0;
        @(negedge clk);
        chk("R11 dsp gate drops with dsp_en", int'(dsp_gate_en), 0);
        chk("R10 core stays on with dsp_en low", int'(core_en), 1);
        dsp_en = 1'b1;
        sys_en = 1'b0;
        @(negedge clk);
        chk("R10 core gate drops with sys_en", int'(core_en), 0);
        chk("R11 dsp gate off while sys_en low", int'(dsp_gate_en), 0);
        sys_en = 1'b1;
        @(negedge clk);
        chk("R10 core gate returns", int'(core_en), 1);
        chk("R11 dsp gate returns", int'(dsp_gate_en), 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_defaults();
        t_sw_table();
        t_bck_table();
        t_ratio_one();
        t_change_mid();
        t_hold();
        t_half_clk();
        t_gates();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule